// File: doc/BRIEF.md
# Eight-bit GPIO port with two-wire peripheral pin override

This block is one 8-bit general-purpose I/O port. It holds two byte-wide registers, a data latch and a direction mask, and both are reached over a plain synchronous register bus. For each pin the block produces an output-enable and an output value, which go to the pad cells. Only bits 7 down to 4 have physical pads. Bits 3 down to 0 have no pads and act as plain storage in both registers.

Bits 7 and 6 can be handed to a two-wire serial peripheral. While `ser_en` is high, pin 7 carries the serial clock and pin 6 carries the serial data. On these two pins the peripheral overrides both the data latch and the direction mask. The peripheral signals a low level with `scl_low_req` or `sda_low_req`, and the block turns each request into open-drain behaviour: it either drives the pin low or releases it, and it never drives it high.

The levels on the two shared pads pass through a two-flop synchronizer before any register read uses them. The register bus carries control, not a data stream, so it has no valid/ready handshake. A read is accepted on every cycle that `bus_rd` is high. Its result appears on `bus_rdata` one clock later and is held there until the next read.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset the data latch and the direction mask are both 0x00, every `pin_oe` bit is 0 and `bus_rdata` is 0x00.
- R2: Offset 0x00E6 selects the data latch and offset 0x00E7 selects the direction mask. A write at either offset updates all 8 bits. A read at 0x00E7 returns all 8 direction bits as they were last written.
- R3: A read at any other offset returns 0x00. A write at any other offset changes neither register.
- R4: For pins 5 and 4, and for pins 7 and 6 while `ser_en` is low: when the direction bit is 1, `pin_oe` is 1 and `pin_out` equals the latch bit; when the direction bit is 0, `pin_oe` is 0.
- R5: For bits 3 to 0, `pin_oe` and `pin_out` are always 0.
- R6: While `ser_en` is high, `pin_oe[7]` equals `scl_low_req`, `pin_oe[6]` equals `sda_low_req`, and `pin_out[7:6]` is 0, whatever the latch and direction hold.
- R7: In a data-register read, bits 5 to 0 return the latch.
- R8: In a data-register read, bit 7 and bit 6 each return the synchronized pad level when `ser_en` is high or that bit's direction is 0. Otherwise they return the latch. A change on a pad reaches a read that is accepted two clocks after the pad changes, or later.
- R9: A data write while `ser_en` is high still updates the latch. The new value reaches pins 7 and 6 once `ser_en` goes low, if their direction bits are 1.
- R10: `bus_rdata` changes only on the clock after a cycle with `bus_rd` high, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| ser_en | input | 1 | Peripheral owns pins 7 and 6 |
| scl_low_req | input | 1 | Peripheral asks to pull the clock line low |
| sda_low_req | input | 1 | Peripheral asks to pull the data line low |
| pin_in | input | 2 | Pad levels of pins 7 (bit 7) and 6 (bit 6) |
| pin_oe | output | 8 | Pad output-enable per bit |
| pin_out | output | 8 | Pad output value per bit |

## Verification
The hardest case to reach is a data read of bits 7 and 6 in which the pad level, the latch and the direction disagree, and the choice of source depends on `ser_en` as well. Only that combination shows whether the read source is selected correctly. The stimulus sets the latch, the direction mask, the pad levels, the enable and both low requests independently at random. Pad levels are held for three clocks before each read, so the synchronizer has settled. Directed steps add an enable toggle around a latch write and reads at offsets next to the mapped pair.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int NPIN      = 8;
  localparam int FIRST_PAD = 4;
  localparam int SCL_BIT   = 7;
  localparam int SDA_BIT   = 6;
  localparam int NSHARE    = 2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DAT  = 2'd1,
    SEL_DIR  = 2'd2
  } reg_sel_e;

  typedef enum logic [1:0] {
    BIT_NOPAD  = 2'd0,
    BIT_PLAIN  = 2'd1,
    BIT_SHARED = 2'd2
  } bit_kind_e;

  function automatic bit_kind_e kind_of(input int b);
    if (b < FIRST_PAD) return BIT_NOPAD;
    if (b == SCL_BIT || b == SDA_BIT) return BIT_SHARED;
    return BIT_PLAIN;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] st1_q;
  logic [W-1:0] st2_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1_q[i] <= 1'b0;
        st2_q[i] <= 1'b0;
      end else begin
        st1_q[i] <= d_async[i];
        st2_q[i] <= st1_q[i];
      end
    end
  end

  assign d_sync = st2_q;
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_ovr_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] DAT_OFS = 16'h00E6,
  parameter logic [15:0] DIR_OFS = 16'h00E7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output reg_sel_e          sel,
  output logic [NPIN-1:0]   dat_q,
  output logic [NPIN-1:0]   dir_q
);
  always_comb begin
    if (bus_addr == ADDR_W'(DAT_OFS))      sel = SEL_DAT;
    else if (bus_addr == ADDR_W'(DIR_OFS)) sel = SEL_DIR;
    else                                   sel = SEL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      dir_q <= '0;
    end else if (bus_wr) begin
      if (sel == SEL_DAT) dat_q <= bus_wdata;
      if (sel == SEL_DIR) dir_q <= bus_wdata;
    end
  end
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
  import gpio_ovr_pkg::*;
(
  input  logic                    ser_en,
  input  logic                    scl_low_req,
  input  logic                    sda_low_req,
  input  logic [NPIN-1:FIRST_PAD] dat_pad,
  input  logic [NPIN-1:FIRST_PAD] dir_pad,
  output logic [NPIN-1:0]         pin_oe,
  output logic [NPIN-1:0]         pin_out
);
  for (genvar b = 0; b < NPIN; b++) begin : g_pin
    if (kind_of(b) == BIT_NOPAD) begin : g_nopad
      assign pin_oe[b]  = 1'b0;
      assign pin_out[b] = 1'b0;
    end else if (kind_of(b) == BIT_PLAIN) begin : g_plain
      assign pin_oe[b]  = dir_pad[b];
      assign pin_out[b] = dat_pad[b];
    end else begin : g_shared
      logic low_req;
      assign low_req    = (b == SCL_BIT) ? scl_low_req : sda_low_req;
      assign pin_oe[b]  = ser_en ? low_req : dir_pad[b];
      assign pin_out[b] = ser_en ? 1'b0    : dat_pad[b];
    end
  end
endmodule

// File: rtl/gpio_rd_path.sv
module gpio_rd_path
  import gpio_ovr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_rd,
  input  reg_sel_e                 sel,
  input  logic                     ser_en,
  input  logic [NPIN-1:0]          dat_q,
  input  logic [NPIN-1:0]          dir_q,
  input  logic [NPIN-1:NPIN-NSHARE] pad_sync,
  output logic [NPIN-1:0]          bus_rdata
);
  logic [NPIN-1:0] dat_view;

  for (genvar b = 0; b < NPIN; b++) begin : g_view
    if (kind_of(b) == BIT_SHARED) begin : g_sh
      assign dat_view[b] = (ser_en || !dir_q[b]) ? pad_sync[b] : dat_q[b];
    end else begin : g_latch
      assign dat_view[b] = dat_q[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (sel)
        SEL_DAT: bus_rdata <= dat_view;
        SEL_DIR: bus_rdata <= dir_q;
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
  import gpio_ovr_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] DAT_OFS = 16'h00E6,
  parameter logic [15:0] DIR_OFS = 16'h00E7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [NPIN-1:0]           bus_wdata,
  output logic [NPIN-1:0]           bus_rdata,
  input  logic                      ser_en,
  input  logic                      scl_low_req,
  input  logic                      sda_low_req,
  input  logic [NPIN-1:NPIN-NSHARE] pin_in,
  output logic [NPIN-1:0]           pin_oe,
  output logic [NPIN-1:0]           pin_out
);
  reg_sel_e                  sel;
  logic [NPIN-1:0]           dat_q;
  logic [NPIN-1:0]           dir_q;
  logic [NPIN-1:NPIN-NSHARE] pad_sync;

  gpio_reg_file #(
    .ADDR_W (ADDR_W),
    .DAT_OFS(DAT_OFS),
    .DIR_OFS(DIR_OFS)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .sel      (sel),
    .dat_q    (dat_q),
    .dir_q    (dir_q)
  );

  gpio_in_sync #(.W(NSHARE)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(pin_in),
    .d_sync (pad_sync)
  );

  gpio_pad_ctl u_pads (
    .ser_en     (ser_en),
    .scl_low_req(scl_low_req),
    .sda_low_req(sda_low_req),
    .dat_pad    (dat_q[NPIN-1:FIRST_PAD]),
    .dir_pad    (dir_q[NPIN-1:FIRST_PAD]),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out)
  );

  gpio_rd_path u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .sel      (sel),
    .ser_en   (ser_en),
    .dat_q    (dat_q),
    .dir_q    (dir_q),
    .pad_sync (pad_sync),
    .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/gpio_port_ovr_chk.sv
module gpio_port_ovr_chk
  import gpio_ovr_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] DAT_OFS = 16'h00E6,
  parameter logic [15:0] DIR_OFS = 16'h00E7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPIN-1:0]   bus_rdata,
  input logic              ser_en,
  input logic              scl_low_req,
  input logic              sda_low_req,
  input logic [NPIN-1:0]   dir_q,
  input logic [NPIN-1:0]   dat_q,
  input logic [NPIN-1:0]   pin_oe,
  input logic [NPIN-1:0]   pin_out
);
  AST_NOPAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe[FIRST_PAD-1:0] == '0) && (pin_out[FIRST_PAD-1:0] == '0)); // R5

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> (pin_out[SCL_BIT] == 1'b0 && pin_out[SDA_BIT] == 1'b0)); // R6

  AST_OD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> (pin_oe[SCL_BIT] == scl_low_req && pin_oe[SDA_BIT] == sda_low_req)); // R6

  AST_PLAIN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe[5:4] == dir_q[5:4]) && ((dir_q[5:4] & (pin_out[5:4] ^ dat_q[5:4])) == '0)); // R4

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != ADDR_W'(DAT_OFS) && bus_addr != ADDR_W'(DIR_OFS))
      |=> (bus_rdata == '0)); // R3

  AST_DIR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(DIR_OFS)) |=> (bus_rdata == $past(dir_q))); // R2
endmodule

bind gpio_port_ovr gpio_port_ovr_chk #(
  .ADDR_W (ADDR_W),
  .DAT_OFS(DAT_OFS),
  .DIR_OFS(DIR_OFS)
) u_chk (.*);

// File: tb/sim_gpio_port_ovr.sv
`timescale 1ns/1ps
module sim_gpio_port_ovr;
  localparam logic [15:0] DAT_A = 16'h00E6;
  localparam logic [15:0] DIR_A = 16'h00E7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ser_en = 1'b0, scl_low_req = 1'b0, sda_low_req = 1'b0;
  logic [7:6] pin_in = '0;
  logic [7:0] pin_oe, pin_out;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_dat = '0, m_dir = '0;

  always #2.5 clk = ~clk;

  gpio_port_ovr u0 (.*);

  function automatic logic [7:0] exp_oe(logic [7:0] dr, logic en, logic scl, logic sda);
    logic [7:0] r = '0;
    r[5:4] = dr[5:4];
    r[7] = en ? scl : dr[7];
    r[6] = en ? sda : dr[6];
    return r;
  endfunction

  function automatic logic [7:0] exp_out(logic [7:0] d, logic en);
    logic [7:0] r = '0;
    r[5:4] = d[5:4];
    r[7:6] = en ? 2'b00 : d[7:6];
    return r;
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] d, logic [7:0] dr, logic en, logic [7:6] p);
    logic [7:0] r = d;
    for (int b = 6; b < 8; b++) r[b] = (en || !dr[b]) ? p[b] : d[b];
    return r;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == DAT_A) m_dat = d;
    if (a == DIR_A) m_dir = d;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic check_pins(string tag);
    chk({tag, " oe"}, pin_oe, exp_oe(m_dir, ser_en, scl_low_req, sda_low_req));
    chk({tag, " out"}, pin_out, exp_out(m_dat, ser_en));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, held;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 out", pin_out, 8'h00);
    chk("R1 rdata", bus_rdata, 8'h00);
    rd(DAT_A, v); chk("R1 data", v, 8'h00);
    rd(DIR_A, v); chk("R1 dir", v, 8'h00);

    // R2 direction readback of all bits, including padless bits
    wr(DIR_A, 8'hA5); rd(DIR_A, v); chk("R2 dir", v, 8'hA5);
    wr(DAT_A, 8'h3C); rd(DAT_A, v); chk("R2/R7 data", v, exp_rd(m_dat, m_dir, 1'b0, pin_in));

    // R3 unmapped offsets
    wr(16'h00E5, 8'hFF); wr(16'h00E8, 8'h00); wr(16'h01E6, 8'h77);
    rd(DAT_A, v); chk("R3 data kept", v, exp_rd(m_dat, m_dir, 1'b0, pin_in));
    rd(DIR_A, v); chk("R3 dir kept", v, 8'hA5);
    rd(16'h00E8, v); chk("R3 unmapped read", v, 8'h00);
    rd(16'h00E5, v); chk("R3 unmapped read lo", v, 8'h00);

    // R10 hold when no read
    held = bus_rdata;
    wr(DAT_A, 8'h81);
    repeat (2) @(negedge clk);
    chk("R10 hold", bus_rdata, held);

    // R4/R5 plain drive
    wr(DIR_A, 8'hFF); wr(DAT_A, 8'hDF);
    check_pins("R4/R5 all out");

    // R9 write while peripheral owns, then release
    @(negedge clk); ser_en = 1'b1; scl_low_req = 1'b1; sda_low_req = 1'b0;
    wr(DAT_A, 8'h40);
    check_pins("R6 override");
    @(negedge clk); ser_en = 1'b0;
    @(negedge clk); check_pins("R9 release");

    // R8 pad read latency: pad set 1 cycle before read edge is too early
    wr(DIR_A, 8'h00); wr(DAT_A, 8'h00);
    pin_in = 2'b00; settle();
    @(negedge clk); pin_in = 2'b11;
    bus_rd = 1'b1; bus_addr = DAT_A;
    @(negedge clk); bus_rd = 1'b0;
    chk("R8 early read", bus_rdata, 8'h00);
    @(negedge clk); @(negedge clk);
    rd(DAT_A, v); chk("R8 synced read", v, 8'hC0);

    // constrained random
    for (int it = 0; it < 300; it++) begin
      int op = $urandom_range(0, 3);
      logic [7:0] d = 8'($urandom);
      if (op == 0) wr(DAT_A, d);
      else if (op == 1) wr(DIR_A, d);
      else if (op == 2) wr(16'($urandom_range(0, 16'h00E5)), d);
      @(negedge clk);
      ser_en = 1'($urandom); scl_low_req = 1'($urandom);
      sda_low_req = 1'($urandom); pin_in = 2'($urandom);
      settle();
      check_pins(ser_en ? "R6 rand" : "R4/R5 rand");
      rd(DAT_A, v); chk("R7/R8 rand data", v, exp_rd(m_dat, m_dir, ser_en, pin_in));
      rd(DIR_A, v); chk("R2/R3 rand dir", v, m_dir);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule